// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Slave

This block is a synthesizable stand-in for the serial register port of a 24-bit sigma-delta converter. An SPI master controller under development can be checked against it. It oversamples the serial pins with the system clock. Every transaction opens with a command byte that selects a register and a direction. The block then accepts or returns the register frame, most significant bit first. It holds a 24-bit operating-mode register and a 24-bit setup register. The setup register carries the gain code.

Conversion results do not come from any modelled analog path. They arrive on a parallel input with a one-cycle valid strobe and land in a read-only 24-bit result register. The shared data-out line carries a ready flag whenever no read frame is being shifted, and that flag drops when an unread result is waiting. A hold-off input freezes result sequencing. A long run of ones on the data input forces the whole interface back to its defaults. After that, the interface stays deaf for a programmable number of system clocks.

Top module: `adcs_slave`

## Requirements
- R1: The serial clock idles high. DIN is taken on each rising serial clock edge, and DOUT changes only after a falling serial clock edge, so DOUT is stable when the master samples at the next rising edge.
- R2: While CS is high, dout_oe is 0, DOUT reads 1, and serial clock edges have no effect on any register.
- R3: The command byte is sent MSB first. Bit 6 set means read and clear means write. Bits 5:3 hold the address: 1 = mode, 2 = setup, 3 = result. So 0x08 writes mode, 0x48 reads mode, 0x10 writes setup, 0x50 reads setup and 0x58 reads the result.
- R4: The mode register is a 24-bit frame written and read MSB first. Its reset value is 0x080060.
- R5: The setup register is a 24-bit frame. Its reset value is 0x000117. The gain code sits in bits 2:0: 111 selects gain 128 and 000 selects gain 1.
- R6: A result read returns the latest accepted 24-bit sample, MSB first. A write to address 3 changes nothing.
- R7: With CS low and no frame being read out, DOUT shows the ready flag. The flag is 0 once a sample has been accepted and returns to 1 when the last bit of a result read has been clocked.
- R8: While SYNC is low, incoming samples are discarded and the ready flag is forced to 1. Register transactions still work.
- R9: Forty consecutive ones on DIN, each clocked with CS low, return mode, setup, result and the ready flag to their reset values. Thirty-nine ones followed by a zero do not.
- R10: For HOLD_CYC system clocks after such a reset, every transaction is ignored. After that time, transactions work normally again.
- R11: A write to address 0 or 4 to 7 carries an 8-bit frame and changes nothing. A read of those addresses returns eight zero bits.
- R12: With CS held low across several transactions (3-wire use), each command byte starts a new transaction straight after the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| din | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| sync_n | input | 1 | Active-low conversion hold-off |
| sample_valid | input | 1 | One-cycle strobe for a new result |
| sample_data | input | 24 | New conversion result |
| dout | output | 1 | Serial data and ready flag to the master, 1 when released |
| dout_oe | output | 1 | Output enable for dout, high while CS is low |

## Verification
Some properties are checked on every cycle by assertions: the ready flag only falls in the cycle after a sample strobe, and a low SYNC forces it high on the next cycle. The output bit only moves on a falling serial edge. The registers stay frozen during the hold-off, and a serial reset lands on the default values. Other behaviours need a whole stimulus sequence, so only the bench scenarios can show them: frame readback values, thirty-nine ones against forty, a write to the result register being discarded, unsupported addresses reading as zeros, and back-to-back transactions with CS held low.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    localparam int DW       = 24;   // register frame width
    localparam int CMD_W    = 8;    // command byte width
    localparam int SHORT_W  = 8;    // frame width of unsupported addresses
    localparam int RST_ONES = 40;   // ones that force a serial reset

    typedef logic [2:0] addr_t;
    localparam addr_t A_MODE  = 3'd1;
    localparam addr_t A_SETUP = 3'd2;
    localparam addr_t A_RES   = 3'd3;

    localparam logic [DW-1:0] MODE_DEF  = 24'h080060;
    localparam logic [DW-1:0] SETUP_DEF = 24'h000117;

    typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

    typedef struct packed {
        logic  rd;
        addr_t addr;
    } cmd_t;

    // takes command byte bits 6:3
    function automatic cmd_t decode_cmd(input logic [3:0] hi);
        cmd_t c;
        c.rd   = hi[3];
        c.addr = hi[2:0];
        return c;
    endfunction

    function automatic logic [4:0] frame_len(input addr_t a);
        if (a == A_MODE || a == A_SETUP || a == A_RES)
            return 5'(DW);
        return 5'(SHORT_W);
    endfunction
endpackage

// File: rtl/adcs_sync_edge.sv
module adcs_sync_edge #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:1] pin_s,
    output logic         rise,
    output logic         fall
);
    logic [STAGES-1:0] q [N];
    logic              prev;

    for (genvar gi = 0; gi < N; gi++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) q[gi] <= '1;
            else     q[gi] <= {q[gi][STAGES-2:0], pin[gi]};
        end
        if (gi > 0) begin : g_out
            assign pin_s[gi] = q[gi][STAGES-1];
        end
    end

    // bit 0 is the serial clock: edge detect after synchronisation
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= q[0][STAGES-1];
    end

    assign rise = q[0][STAGES-1] & ~prev;
    assign fall = ~q[0][STAGES-1] & prev;
endmodule

// File: rtl/adcs_regfile.sv
module adcs_regfile
    import adcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  addr_t         wr_addr,
    input  logic [DW-1:0] wr_data,
    input  addr_t         rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sample_valid,
    input  logic [DW-1:0] sample_data,
    input  logic          sync_ok,
    input  logic          rd_busy,
    input  logic          read_done,
    output logic          rdy_n,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] setup_q
);
    logic [DW-1:0] result_q;
    logic          accept;

    assign accept = sample_valid && sync_ok && !rd_busy;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode_q   <= MODE_DEF;
            setup_q  <= SETUP_DEF;
            result_q <= '0;
            rdy_n    <= 1'b1;
        end else begin
            if (wr_en && wr_addr == A_MODE)  mode_q  <= wr_data;
            if (wr_en && wr_addr == A_SETUP) setup_q <= wr_data;
            if (!sync_ok) begin
                rdy_n <= 1'b1;
            end else if (accept) begin
                result_q <= sample_data;
                rdy_n    <= 1'b0;
            end else if (read_done) begin
                rdy_n <= 1'b1;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = mode_q;
            A_SETUP: rd_data = setup_q;
            A_RES:   rd_data = result_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/adcs_slave.sv
module adcs_slave
    import adcs_pkg::*;
#(
    parameter int HOLD_CYC = 25000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          din,
    input  logic          cs_n,
    input  logic          sync_n,
    input  logic          sample_valid,
    input  logic [DW-1:0] sample_data,
    output logic          dout,
    output logic          dout_oe
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int OW = $clog2(RST_ONES + 1);
    localparam int BW = 5;

    logic [3:1]    pins_s;
    logic          sclk_rise, sclk_fall;
    logic          din_s, cs_s, sync_ok;

    phase_e        phase;
    logic [BW-1:0] bitcnt, cur_len;
    addr_t         cur_addr;
    logic [DW-2:0] shreg;
    logic [DW-1:0] out_sh;
    logic          out_bit, drive;
    logic [OW-1:0] ones;
    logic [HW-1:0] hold_q;

    logic          hold_active, active, bit_ev, serial_rst;
    logic          cmd_done, last_bit, wr_en, read_done, rd_busy;
    cmd_t          cmd_next;
    logic [DW-1:0] rd_data, wr_data, mode_q, setup_q;
    logic          rdy_n;

    adcs_sync_edge #(.N(4), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   ({sync_n, cs_n, din, sclk}),
        .pin_s (pins_s),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    assign din_s   = pins_s[1];
    assign cs_s    = pins_s[2];
    assign sync_ok = pins_s[3];

    assign hold_active = (hold_q != '0);
    assign active      = !hold_active && !cs_s;
    assign bit_ev      = active && sclk_rise;
    assign serial_rst  = bit_ev && din_s && (ones == OW'(RST_ONES - 1));
    // command byte bits 6:3 sit in shreg[5:2] on the eighth edge
    assign cmd_next    = decode_cmd(shreg[5:2]);
    assign cmd_done    = bit_ev && phase == PH_CMD && bitcnt == BW'(CMD_W - 1);
    assign last_bit    = bit_ev && phase != PH_CMD && bitcnt == cur_len - 1'b1;
    assign wr_en       = last_bit && phase == PH_WR;
    assign wr_data     = {shreg, din_s};
    assign read_done   = last_bit && phase == PH_RD && cur_addr == A_RES;
    assign rd_busy     = phase == PH_RD && cur_addr == A_RES;

    always_ff @(posedge clk) begin
        if (rst || serial_rst) begin
            phase    <= PH_CMD;
            bitcnt   <= '0;
            cur_len  <= '0;
            cur_addr <= '0;
            shreg    <= '0;
            out_sh   <= '0;
            out_bit  <= 1'b1;
            drive    <= 1'b0;
            ones     <= '0;
            hold_q   <= rst ? '0 : HW'(HOLD_CYC);
        end else begin
            if (hold_active) hold_q <= hold_q - 1'b1;
            if (!active) begin
                phase  <= PH_CMD;
                bitcnt <= '0;
                drive  <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    ones  <= din_s ? ones + 1'b1 : '0;
                    shreg <= {shreg[DW-3:0], din_s};
                    if (cmd_done) begin
                        cur_addr <= cmd_next.addr;
                        cur_len  <= frame_len(cmd_next.addr);
                        bitcnt   <= '0;
                        phase    <= cmd_next.rd ? PH_RD : PH_WR;
                        if (cmd_next.rd) out_sh <= rd_data;
                    end else if (last_bit) begin
                        phase  <= PH_CMD;
                        bitcnt <= '0;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    drive <= (phase == PH_RD);
                    if (phase == PH_RD) begin
                        out_bit <= out_sh[DW-1];
                        out_sh  <= {out_sh[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end

    adcs_regfile u_regs (
        .clk          (clk),
        .rst          (rst),
        .clr          (serial_rst),
        .wr_en        (wr_en),
        .wr_addr      (cur_addr),
        .wr_data      (wr_data),
        .rd_addr      (cmd_next.addr),
        .rd_data      (rd_data),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .sync_ok      (sync_ok),
        .rd_busy      (rd_busy),
        .read_done    (read_done),
        .rdy_n        (rdy_n),
        .mode_q       (mode_q),
        .setup_q      (setup_q)
    );

    assign dout_oe = ~cs_n;
    assign dout    = cs_n ? 1'b1 : (drive ? out_bit : rdy_n);
endmodule

// File: rtl/adcs_slave_chk.sv
module adcs_slave_chk
    import adcs_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          sync_ok,
    input logic          rdy_n,
    input logic          sample_valid,
    input logic          sclk_fall,
    input logic          serial_rst,
    input logic          out_bit,
    input logic          hold_active,
    input logic [DW-1:0] mode_q,
    input logic [DW-1:0] setup_q
);
    // R1: the shifted bit only moves on a falling serial edge
    a_r1_out_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !serial_rst) |=> $stable(out_bit));

    // R7: ready only drops right after a sample strobe
    a_r7_rdy_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $past(sample_valid));

    // R8: hold-off forces ready high
    a_r8_sync_rdy: assert property (@(posedge clk) disable iff (rst)
        !sync_ok |=> rdy_n);

    // R9: serial reset lands on defaults and starts the hold-off
    a_r9_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        serial_rst |=> (mode_q == MODE_DEF && setup_q == SETUP_DEF && rdy_n && hold_active));

    // R10: registers frozen during hold-off
    a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        hold_active |=> ($stable(mode_q) && $stable(setup_q)));
endmodule

bind adcs_slave adcs_slave_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sync_ok      (sync_ok),
    .rdy_n        (rdy_n),
    .sample_valid (sample_valid),
    .sclk_fall    (sclk_fall),
    .serial_rst   (serial_rst),
    .out_bit      (out_bit),
    .hold_active  (hold_active),
    .mode_q       (mode_q),
    .setup_q      (setup_q)
);

// File: tb/sim_adcs_slave.sv
module sim_adcs_slave;
    import adcs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 1500;
    localparam int HALF       = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b1;
    logic          din = 1'b0;
    logic          cs_n = 1'b1;
    logic          sync_n = 1'b1;
    logic          sample_valid = 1'b0;
    logic [DW-1:0] sample_data = '0;
    logic          dout, dout_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    logic [DW-1:0] m_mode, m_setup, m_res;
    logic          m_rdy_n;

    adcs_slave #(.HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .din(din), .cs_n(cs_n),
        .sync_n(sync_n), .sample_valid(sample_valid), .sample_data(sample_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R2: every clock, the release state follows CS
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_vec++;
            if (dout_oe !== !cs_n || (cs_n && dout !== 1'b1)) begin
                n_bad++;
                $display("FAIL R2: actual oe=%b dout=%b expected oe=%b", dout_oe, dout, !cs_n);
            end
        end
    end

    task automatic bit_xfer(input logic b, output logic r);
        sclk = 1'b0;
        tick(HALF/2);
        din = b;
        tick(HALF/2);
        r = dout;
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic frame(input int n, input logic [DW-1:0] tx, output logic [DW-1:0] rx);
        logic r;
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_xfer(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_hi();
        tick(4);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic spi_wr(input logic [7:0] cmd, input logic [DW-1:0] val, input int n);
        logic [DW-1:0] junk;
        cs_lo();
        frame(8, {16'h0, cmd}, junk);
        frame(n, val, junk);
        cs_hi();
    endtask

    task automatic spi_rd(input logic [7:0] cmd, input int n, output logic [DW-1:0] v);
        logic [DW-1:0] junk;
        cs_lo();
        frame(8, {16'h0, cmd}, junk);
        frame(n, '0, v);
        cs_hi();
    endtask

    task automatic rdy_probe(output logic v);
        cs_n = 1'b0;
        tick(4);
        v = dout;
        tick(2);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic push(input logic [DW-1:0] d);
        sample_data  = d;
        sample_valid = 1'b1;
        tick(1);
        sample_valid = 1'b0;
        if (sync_n) begin
            m_res   = d;
            m_rdy_n = 1'b0;
        end
        tick(2);
    endtask

    task automatic ones_run(input int n, input logic tail);
        logic r;
        cs_lo();
        for (int i = 0; i < n; i++) bit_xfer(1'b1, r);
        if (tail === 1'b0) bit_xfer(1'b0, r);
        cs_hi();
    endtask

    initial begin
        logic [DW-1:0] v, junk;
        logic          f;
        m_mode = MODE_DEF; m_setup = SETUP_DEF; m_res = '0; m_rdy_n = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(5);

        // reset state
        chk("R2 oe idle", {23'h0, dout_oe}, 24'h0);
        chk("R2 dout idle", {23'h0, dout}, 24'h1);
        rdy_probe(f);
        chk("R7 no result yet", {23'h0, f}, {23'h0, m_rdy_n});
        spi_rd(8'h48, 24, v);
        chk("R4 mode default", v, m_mode);
        spi_rd(8'h50, 24, v);
        chk("R5 setup default", v, m_setup);
        chk("R5 gain 128 code", {21'h0, v[2:0]}, 24'h7);

        // R3/R4 write and readback of mode
        spi_wr(8'h08, 24'h123456, 24); m_mode = 24'h123456;
        spi_rd(8'h48, 24, v);
        chk("R3 R4 mode write", v, m_mode);

        // R5 gain 1
        spi_wr(8'h10, 24'h000A10, 24); m_setup = 24'h000A10;
        spi_rd(8'h50, 24, v);
        chk("R5 setup write", v, m_setup);
        chk("R5 gain 1 code", {21'h0, v[2:0]}, 24'h0);

        // R7/R6 result path
        push(24'hA5C3F0);
        rdy_probe(f);
        chk("R7 ready low", {23'h0, f}, {23'h0, m_rdy_n});
        spi_rd(8'h58, 24, v); m_rdy_n = 1'b1;
        chk("R6 result read", v, m_res);
        rdy_probe(f);
        chk("R7 ready high after read", {23'h0, f}, {23'h0, m_rdy_n});
        spi_wr(8'h18, 24'hFFFFFF, 24);
        spi_rd(8'h58, 24, v);
        chk("R6 result write ignored", v, m_res);

        // R11 unsupported addresses
        spi_wr(8'h38, 24'h0000FF, 8);
        spi_wr(8'h00, 24'h0000AA, 8);
        spi_rd(8'h48, 24, v);
        chk("R11 mode kept", v, m_mode);
        spi_rd(8'h50, 24, v);
        chk("R11 setup kept", v, m_setup);
        spi_rd(8'h78, 8, v);
        chk("R11 read zeros", v, 24'h0);

        // R8 hold-off input
        push(24'h111111);
        sync_n = 1'b0; m_rdy_n = 1'b1;
        tick(4);
        rdy_probe(f);
        chk("R8 ready forced high", {23'h0, f}, 24'h1);
        push(24'h222222);
        spi_rd(8'h48, 24, v);
        chk("R8 serial still works", v, m_mode);
        sync_n = 1'b1;
        tick(4);
        rdy_probe(f);
        chk("R8 ready stays high", {23'h0, f}, 24'h1);
        spi_rd(8'h58, 24, v);
        chk("R8 sample discarded", v, 24'h111111);
        push(24'h333333);
        rdy_probe(f);
        chk("R8 sample accepted again", {23'h0, f}, 24'h0);
        spi_rd(8'h58, 24, v); m_rdy_n = 1'b1;
        chk("R8 new result", v, m_res);

        // R2 serial clock ignored with CS high
        for (int i = 0; i < 48; i++) begin
            din = i[0];
            sclk = 1'b0; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        spi_rd(8'h48, 24, v);
        chk("R2 sclk ignored", v, m_mode);

        // R12 CS held low, back-to-back transactions
        cs_lo();
        frame(8, 24'h10, junk);
        frame(24, 24'h000333, junk); m_setup = 24'h000333;
        frame(8, 24'h50, junk);
        frame(24, '0, v);
        chk("R12 setup readback", v, m_setup);
        frame(8, 24'h48, junk);
        frame(24, '0, v);
        chk("R12 mode readback", v, m_mode);
        cs_hi();

        // R9 thirty-nine ones then a zero: no reset
        push(24'h444444);
        ones_run(39, 1'b0);
        spi_rd(8'h48, 24, v);
        chk("R9 39 ones no reset", v, m_mode);
        rdy_probe(f);
        chk("R9 ready kept", {23'h0, f}, 24'h0);

        // R9 forty ones: reset, then R10 hold-off
        ones_run(40, 1'b1);
        m_mode = MODE_DEF; m_setup = SETUP_DEF; m_res = '0; m_rdy_n = 1'b1;
        spi_wr(8'h08, 24'h555555, 24);   // inside the hold-off window
        tick(HOLD);
        spi_rd(8'h48, 24, v);
        chk("R9 R10 mode default", v, m_mode);
        spi_rd(8'h50, 24, v);
        chk("R9 setup default", v, m_setup);
        rdy_probe(f);
        chk("R9 ready high", {23'h0, f}, 24'h1);
        spi_rd(8'h58, 24, v);
        chk("R9 result cleared", v, m_res);
        spi_wr(8'h08, 24'h0ABCDE, 24); m_mode = 24'h0ABCDE;
        spi_rd(8'h48, 24, v);
        chk("R10 works after hold-off", v, m_mode);

        // R1 bit order check on an asymmetric pattern
        push(24'h800001);
        spi_rd(8'h58, 24, v);
        chk("R1 R6 MSB first", v, 24'h800001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule